// File: doc/BRIEF.md
# Lockable Translation Buffer

A small fully associative buffer of virtual-to-physical page mappings in which software can pin entries so that they survive a bulk flush. Commands arrive on a valid/ready port. A lookup answers straight from the stored entries. A fill or a translate-and-lock command asks an external page-table walker for the mapping over a request/response port, then installs the result in the buffer.

A locked entry is created only by the translate-and-lock command. The only way to release locks is a global unlock. The invalidate-all command removes unlocked entries and leaves pinned ones in place. If a lock attempt faults, a dedicated abort code is returned and the buffer stays exactly as it was. The block is a single unified instance. The data-side lock and unlock opcodes are the active ones, and the instruction-side opcodes are accepted and then ignored.

Back-pressure rules: a command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low from the acceptance of a walking command until that command's walk response has been consumed. `walk_req_valid` stays high, with a stable address, until `walk_req_ready` is seen. Walk responses carry no ready signal. One is taken only while the block is waiting for it. Every accepted command produces exactly one `rsp_valid` pulse.

Top module: `lockable_tlb`

## Requirements
- R1: A LOOKUP (opcode 0) raises `rsp_valid` in the cycle after acceptance. If a valid entry matches, it returns `rsp_hit`=1, status OK (0), and that entry's physical page and attributes. Otherwise it returns `rsp_hit`=0 and status MISS (1).
- R2: A LOCK (opcode 2) issues a walk request carrying the command's virtual page. A fault-free walk response installs a valid, locked entry, returns status OK, and returns the walked physical page in `rsp_ppage`.
- R3: When the walk for a LOCK reports an external abort or a translation fault, the status is LOCK_ABORT (3) and no entry, valid bit or lock bit changes.
- R4: A FILL (opcode 1) walks like a LOCK but installs an unlocked entry. A faulting walk for a FILL returns XLAT_ABORT (2) and changes nothing.
- R5: UNLOCK (opcode 4) clears every lock bit at once and returns OK. The entries it unlocked remain valid.
- R6: INVALIDATE-ALL (opcode 6) removes every unlocked entry, keeps every locked entry valid, and returns OK.
- R7: INVALIDATE-BY-ADDRESS (opcode 7) removes a matching entry even if it is locked and clears its lock bit. The status is OK whether or not an entry matched.
- R8: A LOCK or FILL whose page already matches a valid entry returns DUPLICATE (4) one cycle after acceptance and issues no walk.
- R9: The entry to be replaced is the first unlocked slot found when searching upward, with wrap-around, from a pointer that starts at slot 0 after reset. The pointer moves to the slot after each installed entry.
- R10: When every slot is locked, a LOCK or FILL returns FULL (5) with no walk and no change to the buffer.
- R11: The instruction-side opcodes LOCK_I (3) and UNLOCK_I (5) return IGNORED (6), issue no walk, and leave all lock and valid state unchanged.
- R12: `cmd_ready` stays low while a walk is outstanding. `walk_req_valid` and `walk_req_vpage` hold until `walk_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 3 | Opcode |
| cmd_vpage | input | VPW | Virtual page of the command |
| walk_req_valid | output | 1 | Walk request offered |
| walk_req_ready | input | 1 | Walker accepts the request |
| walk_req_vpage | output | VPW | Virtual page to translate |
| walk_rsp_valid | input | 1 | Walk result present |
| walk_rsp_ppage | input | PPW | Walked physical page |
| walk_rsp_attr | input | AW | Walked attributes |
| walk_rsp_ext_abort | input | 1 | External abort during walk |
| walk_rsp_xlat_fault | input | 1 | Translation fault during walk |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 3 | Status code |
| rsp_hit | output | 1 | Lookup hit |
| rsp_ppage | output | PPW | Physical page result |
| rsp_attr | output | AW | Attribute result |

## Verification
The hardest state to reach is a buffer in which every slot is locked after a round-robin pointer has had to skip locked slots. The stimulus gets there in steps. It pins one entry, fills the rest, locks three more so that the victim search must step past the pinned slot, and then shows that further LOCK and FILL commands report FULL and that the instruction-side opcodes do not disturb the pins. The same counting is used to check that invalidating a locked entry by address clears its lock bit. After that invalidation, four consecutive locks must all succeed and a fifth must report FULL.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [2:0] {
    OP_LOOKUP   = 3'd0,
    OP_FILL     = 3'd1,
    OP_LOCK     = 3'd2,
    OP_LOCK_I   = 3'd3,
    OP_UNLOCK   = 3'd4,
    OP_UNLOCK_I = 3'd5,
    OP_INV_ALL  = 3'd6,
    OP_INV_VA   = 3'd7
  } tlb_op_e;

  typedef enum logic [2:0] {
    ST_OK         = 3'd0,
    ST_MISS       = 3'd1,
    ST_XLAT_ABORT = 3'd2,
    ST_LOCK_ABORT = 3'd3,
    ST_DUP        = 3'd4,
    ST_FULL       = 3'd5,
    ST_IGNORED    = 3'd6
  } tlb_status_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_WAIT = 2'd2
  } tlb_state_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N   = 4,
  parameter int VPW = 20,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   valid,
  input  logic [N*VPW-1:0] tags,
  input  logic [VPW-1:0] key,
  output logic           hit,
  output logic [IW-1:0]  hit_idx
);
  logic [N-1:0] hit_vec;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (tags[g*VPW +: VPW] == key);
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) begin
        hit     = 1'b1;
        hit_idx = IW'(i);
      end
    end
  end

  // R8: duplicate rejection keeps at most one matching entry
  assert_unique_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N   = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  locked,
  input  logic [IW-1:0] ptr,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic [IW-1:0] next_ptr
);
  always_comb begin
    logic [IW:0] j;
    found = 1'b0;
    idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      j = {1'b0, ptr} + (IW+1)'(k);
      if (j >= (IW+1)'(N)) j = j - (IW+1)'(N);
      if (!locked[j[IW-1:0]]) begin
        found = 1'b1;
        idx   = j[IW-1:0];
      end
    end
    next_ptr = (idx == IW'(N - 1)) ? '0 : idx + 1'b1;
  end

  assert_victim_unlocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> !locked[idx]);
  assert_full_only_if_all_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !found |-> (&locked));
endmodule

// File: rtl/lockable_tlb.sv
module lockable_tlb
  import tlb_pkg::*;
#(
  parameter int N   = 4,
  parameter int VPW = 20,
  parameter int PPW = 20,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic [2:0]     cmd_op,
  input  logic [VPW-1:0] cmd_vpage,
  output logic           walk_req_valid,
  input  logic           walk_req_ready,
  output logic [VPW-1:0] walk_req_vpage,
  input  logic           walk_rsp_valid,
  input  logic [PPW-1:0] walk_rsp_ppage,
  input  logic [AW-1:0]  walk_rsp_attr,
  input  logic           walk_rsp_ext_abort,
  input  logic           walk_rsp_xlat_fault,
  output logic           rsp_valid,
  output logic [2:0]     rsp_status,
  output logic           rsp_hit,
  output logic [PPW-1:0] rsp_ppage,
  output logic [AW-1:0]  rsp_attr
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  tlb_state_e     state;
  tlb_op_e        op_in, op_q;
  logic [VPW-1:0] va_q;
  logic [N-1:0]   valid_q, lock_q;
  logic [VPW-1:0] vpage_q [N];
  logic [PPW-1:0] ppage_q [N];
  logic [AW-1:0]  attr_q  [N];
  logic [IW-1:0]  rr_q;
  logic [N*VPW-1:0] tag_flat;

  logic          hit, vic_found;
  logic [IW-1:0] hit_idx, vic_idx, vic_next;
  logic          accept, walk_fault;

  for (genvar g = 0; g < N; g++) begin : g_pack
    assign tag_flat[g*VPW +: VPW] = vpage_q[g];
  end

  assign op_in          = tlb_op_e'(cmd_op);
  assign cmd_ready      = (state == S_IDLE);
  assign accept         = cmd_valid && cmd_ready;
  assign walk_req_valid = (state == S_REQ);
  assign walk_req_vpage = va_q;
  assign walk_fault     = walk_rsp_ext_abort || walk_rsp_xlat_fault;

  tlb_match #(.N(N), .VPW(VPW)) u_match (
    .clk(clk), .rst_n(rst_n), .valid(valid_q), .tags(tag_flat),
    .key(cmd_vpage), .hit(hit), .hit_idx(hit_idx)
  );

  tlb_victim #(.N(N)) u_victim (
    .clk(clk), .rst_n(rst_n), .locked(lock_q), .ptr(rr_q),
    .found(vic_found), .idx(vic_idx), .next_ptr(vic_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      op_q       <= OP_LOOKUP;
      va_q       <= '0;
      valid_q    <= '0;
      lock_q     <= '0;
      rr_q       <= '0;
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_hit    <= 1'b0;
      rsp_ppage  <= '0;
      rsp_attr   <= '0;
      for (int i = 0; i < N; i++) begin
        vpage_q[i] <= '0;
        ppage_q[i] <= '0;
        attr_q[i]  <= '0;
      end
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          rsp_hit   <= 1'b0;
          rsp_ppage <= '0;
          rsp_attr  <= '0;
          case (op_in)
            OP_LOOKUP: begin
              rsp_valid  <= 1'b1;
              rsp_status <= hit ? ST_OK : ST_MISS;
              rsp_hit    <= hit;
              if (hit) begin
                rsp_ppage <= ppage_q[hit_idx];
                rsp_attr  <= attr_q[hit_idx];
              end
            end
            OP_FILL, OP_LOCK: begin
              if (hit) begin
                rsp_valid  <= 1'b1;
                rsp_status <= ST_DUP;
              end else if (!vic_found) begin
                rsp_valid  <= 1'b1;
                rsp_status <= ST_FULL;
              end else begin
                op_q  <= op_in;
                va_q  <= cmd_vpage;
                state <= S_REQ;
              end
            end
            OP_UNLOCK: begin
              lock_q     <= '0;
              rsp_valid  <= 1'b1;
              rsp_status <= ST_OK;
            end
            OP_INV_ALL: begin
              valid_q    <= valid_q & lock_q;
              rsp_valid  <= 1'b1;
              rsp_status <= ST_OK;
            end
            OP_INV_VA: begin
              if (hit) begin
                valid_q[hit_idx] <= 1'b0;
                lock_q[hit_idx]  <= 1'b0;
              end
              rsp_valid  <= 1'b1;
              rsp_status <= ST_OK;
            end
            default: begin
              rsp_valid  <= 1'b1;
              rsp_status <= ST_IGNORED;
            end
          endcase
        end
        S_REQ: if (walk_req_ready) state <= S_WAIT;
        S_WAIT: if (walk_rsp_valid) begin
          state     <= S_IDLE;
          rsp_valid <= 1'b1;
          rsp_hit   <= 1'b0;
          if (walk_fault) begin
            rsp_status <= (op_q == OP_LOCK) ? ST_LOCK_ABORT : ST_XLAT_ABORT;
            rsp_ppage  <= '0;
            rsp_attr   <= '0;
          end else begin
            valid_q[vic_idx] <= 1'b1;
            lock_q[vic_idx]  <= (op_q == OP_LOCK);
            vpage_q[vic_idx] <= va_q;
            ppage_q[vic_idx] <= walk_rsp_ppage;
            attr_q[vic_idx]  <= walk_rsp_attr;
            rr_q             <= vic_next;
            rsp_status       <= ST_OK;
            rsp_ppage        <= walk_rsp_ppage;
            rsp_attr         <= walk_rsp_attr;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_lookup_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_in == OP_LOOKUP) |=> (rsp_valid && (rsp_status == ST_OK || rsp_status == ST_MISS)));
  assert_lock_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q & ~valid_q) == '0);
  assert_lockabort_nochange_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && walk_rsp_valid && walk_fault && op_q == OP_LOCK)
      |=> ($stable(valid_q) && $stable(lock_q) && rsp_status == ST_LOCK_ABORT));
  assert_unlock_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_in == OP_UNLOCK) |=> (lock_q == '0));
  assert_invall_keeps_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_in == OP_INV_ALL) |=> ((valid_q & $past(lock_q)) == $past(lock_q)));
  assert_dup_no_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (op_in == OP_LOCK || op_in == OP_FILL) && hit)
      |=> (!walk_req_valid && rsp_valid && rsp_status == ST_DUP));
  assert_ign_no_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (op_in == OP_LOCK_I || op_in == OP_UNLOCK_I))
      |=> ($stable(lock_q) && $stable(valid_q) && !walk_req_valid));
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_valid && !walk_req_ready) |=> (walk_req_valid && $stable(walk_req_vpage)));
endmodule

// File: tb/lockable_tlb_bench.sv
module lockable_tlb_bench;
  localparam logic [2:0] LOOKUP = 3'd0, FILL = 3'd1, LOCK = 3'd2, LOCK_I = 3'd3,
                         UNLOCK = 3'd4, UNLOCK_I = 3'd5, INV_ALL = 3'd6, INV_VA = 3'd7;
  localparam logic [2:0] OK = 3'd0, MISS = 3'd1, XABT = 3'd2, LABT = 3'd3,
                         DUP = 3'd4, FULL = 3'd5, IGN = 3'd6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [19:0] cmd_vpage = '0;
  logic walk_req_valid, walk_req_ready = 1'b0;
  logic [19:0] walk_req_vpage;
  logic walk_rsp_valid = 1'b0;
  logic [19:0] walk_rsp_ppage = '0;
  logic [3:0] walk_rsp_attr = '0;
  logic walk_rsp_ext_abort = 1'b0, walk_rsp_xlat_fault = 1'b0;
  logic rsp_valid, rsp_hit;
  logic [2:0] rsp_status;
  logic [19:0] rsp_ppage;
  logic [3:0] rsp_attr;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lockable_tlb u_lockable_tlb (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_vpage(cmd_vpage), .walk_req_valid(walk_req_valid),
    .walk_req_ready(walk_req_ready), .walk_req_vpage(walk_req_vpage),
    .walk_rsp_valid(walk_rsp_valid), .walk_rsp_ppage(walk_rsp_ppage),
    .walk_rsp_attr(walk_rsp_attr), .walk_rsp_ext_abort(walk_rsp_ext_abort),
    .walk_rsp_xlat_fault(walk_rsp_xlat_fault), .rsp_valid(rsp_valid),
    .rsp_status(rsp_status), .rsp_hit(rsp_hit), .rsp_ppage(rsp_ppage),
    .rsp_attr(rsp_attr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [19:0] va);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_vpage = va;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic simple(input string tag, input logic [2:0] op, input logic [19:0] va,
                        input logic [2:0] st);
    send(op, va);
    check({tag, " rsp_valid"}, rsp_valid, 1);
    check({tag, " status"}, rsp_status, st);
    check({tag, " no walk"}, walk_req_valid, 0);
  endtask

  task automatic lookup(input string tag, input logic [19:0] va, input bit exp_hit,
                        input logic [19:0] pp);
    send(LOOKUP, va);
    check({tag, " R1 rsp_valid"}, rsp_valid, 1);
    check({tag, " R1 hit"}, rsp_hit, exp_hit);
    check({tag, " R1 status"}, rsp_status, exp_hit ? OK : MISS);
    if (exp_hit) check({tag, " R1 ppage"}, rsp_ppage, pp);
  endtask

  task automatic walk_cmd(input string tag, input logic [2:0] op, input logic [19:0] va,
                          input logic [19:0] pp, input bit ext, input bit flt,
                          input logic [2:0] st);
    send(op, va);
    check({tag, " R12 no early rsp"}, rsp_valid, 0);
    check({tag, " R2 req valid"}, walk_req_valid, 1);
    check({tag, " R2 req vpage"}, walk_req_vpage, va);
    check({tag, " R12 busy"}, cmd_ready, 0);
    @(negedge clk);
    check({tag, " R12 req held"}, walk_req_valid, 1);
    walk_req_ready = 1'b1;
    @(negedge clk);
    walk_req_ready = 1'b0;
    check({tag, " R12 req dropped"}, walk_req_valid, 0);
    repeat (2) @(negedge clk);
    check({tag, " R12 busy wait"}, cmd_ready, 0);
    walk_rsp_valid = 1'b1; walk_rsp_ppage = pp; walk_rsp_attr = pp[3:0];
    walk_rsp_ext_abort = ext; walk_rsp_xlat_fault = flt;
    @(negedge clk);
    walk_rsp_valid = 1'b0; walk_rsp_ext_abort = 1'b0; walk_rsp_xlat_fault = 1'b0;
    check({tag, " rsp_valid"}, rsp_valid, 1);
    check({tag, " status"}, rsp_status, st);
    if (st == OK) begin
      check({tag, " R2 ppage"}, rsp_ppage, pp);
      check({tag, " R2 attr"}, rsp_attr, pp[3:0]);
    end
  endtask

  task automatic t_reset();
    check("reset R12 cmd_ready", cmd_ready, 1);
    check("reset rsp_valid", rsp_valid, 0);
    check("reset walk_req_valid", walk_req_valid, 0);
    lookup("reset miss", 20'h100, 0, 0);
  endtask

  task automatic t_fill_lock();
    walk_cmd("fill A R4", FILL, 20'h10, 20'h0AA, 0, 0, OK);
    walk_cmd("lock B R2", LOCK, 20'h20, 20'h0BB, 0, 0, OK);
    lookup("hit A", 20'h10, 1, 20'h0AA);
    lookup("hit B R2", 20'h20, 1, 20'h0BB);
    simple("dup lock A R8", LOCK, 20'h10, DUP);
    simple("dup fill B R8", FILL, 20'h20, DUP);
  endtask

  task automatic t_aborts();
    walk_cmd("lock C ext R3", LOCK, 20'h30, 20'h0CC, 1, 0, LABT);
    walk_cmd("lock C flt R3", LOCK, 20'h30, 20'h0CC, 0, 1, LABT);
    walk_cmd("fill C ext R4", FILL, 20'h30, 20'h0CC, 1, 0, XABT);
    lookup("C absent R3", 20'h30, 0, 0);
    lookup("A kept R3", 20'h10, 1, 20'h0AA);
    lookup("B kept R3", 20'h20, 1, 20'h0BB);
  endtask

  task automatic t_invall();
    simple("inv all R6", INV_ALL, 20'h0, OK);
    lookup("A gone R6", 20'h10, 0, 0);
    lookup("B pinned R6", 20'h20, 1, 20'h0BB);
  endtask

  task automatic t_round_robin();
    walk_cmd("fill C R9", FILL, 20'h30, 20'h0CC, 0, 0, OK);
    walk_cmd("fill D R9", FILL, 20'h40, 20'h0DD, 0, 0, OK);
    walk_cmd("fill E R9", FILL, 20'h50, 20'h0EE, 0, 0, OK);
    walk_cmd("fill F R9", FILL, 20'h60, 20'h0FF, 0, 0, OK);
    lookup("C evicted R9", 20'h30, 0, 0);
    lookup("D kept R9", 20'h40, 1, 20'h0DD);
    lookup("E kept R9", 20'h50, 1, 20'h0EE);
    lookup("F kept R9", 20'h60, 1, 20'h0FF);
    lookup("B skipped R9", 20'h20, 1, 20'h0BB);
  endtask

  task automatic t_full_ignore();
    walk_cmd("lock G R9", LOCK, 20'h70, 20'h011, 0, 0, OK);
    walk_cmd("lock H R9", LOCK, 20'h80, 20'h022, 0, 0, OK);
    walk_cmd("lock I R9", LOCK, 20'h90, 20'h033, 0, 0, OK);
    lookup("D evicted R9", 20'h40, 0, 0);
    lookup("F evicted R9", 20'h60, 0, 0);
    simple("lock full R10", LOCK, 20'hA0, FULL);
    simple("fill full R10", FILL, 20'hA0, FULL);
    lookup("J absent R10", 20'hA0, 0, 0);
    simple("lock_i R11", LOCK_I, 20'hA0, IGN);
    simple("unlock_i R11", UNLOCK_I, 20'h0, IGN);
    simple("still full R11", LOCK, 20'hA0, FULL);
    lookup("G pinned R11", 20'h70, 1, 20'h011);
  endtask

  task automatic t_unlock();
    simple("unlock R5", UNLOCK, 20'h0, OK);
    lookup("B still valid R5", 20'h20, 1, 20'h0BB);
    simple("inv all after unlock R5", INV_ALL, 20'h0, OK);
    lookup("B gone R5", 20'h20, 0, 0);
    lookup("G gone R5", 20'h70, 0, 0);
  endtask

  task automatic t_inv_va();
    walk_cmd("lock K R7", LOCK, 20'hB0, 20'h044, 0, 0, OK);
    simple("inv va K R7", INV_VA, 20'hB0, OK);
    lookup("K gone R7", 20'hB0, 0, 0);
    simple("inv va miss R7", INV_VA, 20'hB0, OK);
    walk_cmd("lock M1 R7", LOCK, 20'hC1, 20'h051, 0, 0, OK);
    walk_cmd("lock M2 R7", LOCK, 20'hC2, 20'h052, 0, 0, OK);
    walk_cmd("lock M3 R7", LOCK, 20'hC3, 20'h053, 0, 0, OK);
    walk_cmd("lock M4 R7", LOCK, 20'hC4, 20'h054, 0, 0, OK);
    simple("lock M5 full R7", LOCK, 20'hC5, FULL);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_lock();
    t_aborts();
    t_invall();
    t_round_robin();
    t_full_ignore();
    t_unlock();
    t_inv_va();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule